// File: doc/BRIEF.md
# Consumer-Electronics-Control Frame Receiver

This block listens to a single open-drain control line shared by several devices. It times each start bit and each data bit against tolerance windows, samples every data bit at a fixed point after its falling edge, and collects the bytes of a frame into a buffer. If the destination of the frame is one of its own logical addresses, it acknowledges every byte by holding the line low through the acknowledge slot. If a bit period is too short, it pulls the line low for one and a half bit periods to signal an error.

The line level must already be synchronized to `clk`. All timing runs off a one-microsecond tick enable, and every limit is a parameter given in ticks. The buffer is cleared at each frame start. When a frame ends with its end-of-message bit, `msgValid` pulses for one cycle. The length and buffer contents then stay stable until the next falling edge that reaches an idle receiver.

Top module: `cec_rx_top`

## Requirements
- R1: After reset `driveLow` is 0, `msgValid` is 0 and `rxLen` is 0.
- R2: A falling edge while idle starts a start bit. If the line rises fewer than START_LOW_MIN ticks after that edge, the frame is rejected and nothing is received. A rise at exactly START_LOW_MIN ticks is accepted.
- R3: If no falling edge follows within START_TOTAL_MAX ticks of the start-bit edge, the frame is abandoned.
- R4: Each data bit is sampled SAMPLE_AT ticks after its falling edge, and a high line reads as 1. Bits 0 to 7 of every ten-bit group form one byte, MSB first. Byte i appears at `rxBuf[8*i+7:8*i]`.
- R5: Bit 8 of a group is end-of-message, and sampling it sets `rxLen` to the byte index plus one. After the acknowledge slot of a byte whose end-of-message bit is 1, `msgValid` goes high for exactly one cycle: the cycle after the first clock edge that sees the line high.
- R6: If no falling edge follows within BIT_TOTAL_MAX ticks of a data bit's falling edge, the frame is abandoned and no `msgValid` is given.
- R7: A falling edge that arrives fewer than BIT_TOTAL_MIN ticks after the previous bit's edge makes `driveLow` high for exactly ERR_LOW_T cycles from that edge. The frame is dropped.
- R8: The destination is bits 3:0 of byte 0. If the mask bit for that destination is set, `driveLow` is high for exactly ACK_LOW_T cycles starting at the falling edge of every acknowledge slot.
- R9: Destination 15 (broadcast) and destinations whose mask bit is clear never cause `driveLow`.
- R10: After the final acknowledge slot, falling edges are ignored until BIT_TOTAL_MIN ticks after that slot's edge.
- R11: Bytes beyond MAX_BYTES are timed but not stored, and `rxLen` saturates at MAX_BYTES.
- R12: The whole buffer and the length are cleared to zero at every frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickUs | input | 1 | One-microsecond timing enable |
| lineIn | input | 1 | Synchronized bus level, 1 = released |
| addrMask | input | 15 | One bit per logical address 0..14 that this node answers |
| driveLow | output | 1 | 1 = pull the bus low |
| rxBuf | output | MAX_BYTES*8 | Received bytes, byte i at bits 8i+7:8i |
| rxLen | output | $clog2(MAX_BYTES+1) | Number of bytes received |
| msgValid | output | 1 | One-cycle pulse when a complete frame is acknowledged |

## Verification
The assertions assume that `lineIn` is clean and synchronized, and that it falls only while the line is genuinely released by this block and pulled low by someone else. In other words, the line behaves as a wired-AND of the external driver and `driveLow`. The bench models the line exactly that way. It changes the external level only on the falling clock edge and holds `tickUs` high, so one tick equals one clock. It uses bit timings scaled down by ten, which keeps every edge well clear of the limits except where a boundary is being tested on purpose.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;

  localparam int ADDR_SLOTS = 15;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START_LOW,
    S_START_HIGH,
    S_BIT_SAMPLE,
    S_BIT_WAIT,
    S_ACK_DRIVE,
    S_ACK_POST,
    S_FINISH,
    S_ERR_DRIVE
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic frameClr;  // new frame: clear buffer and indices
    logic capture;   // sample point of a data or end-of-message bit
    logic advance;   // next bit slot begins
  } dpCtl_t;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cec_rx_dp.sv
module cec_rx_dp
  import cec_rx_pkg::*;
#(
  parameter int MAX_BYTES = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             lineIn,
  input  dpCtl_t                           dpCtl,
  output logic [3:0]                       slotIdx,
  output logic                             eomFlag,
  output logic [3:0]                       destAddr,
  output logic [MAX_BYTES*8-1:0]           rxBuf,
  output logic [$clog2(MAX_BYTES+1)-1:0]   rxLen
);

  localparam int IDX_W = $clog2(MAX_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(MAX_BYTES);

  logic [IDX_W-1:0] byteIdx;
  logic [7:0]       byteMem [MAX_BYTES];
  logic             dataSlot;

  assign dataSlot = (slotIdx < 4'd8);

  always_ff @(posedge clk) begin
    if (!rstN || dpCtl.frameClr) begin
      byteIdx <= '0;
      slotIdx <= '0;
      eomFlag <= 1'b0;
      rxLen   <= '0;
    end else begin
      if (dpCtl.capture && slotIdx == 4'd8) begin
        eomFlag <= lineIn;
        rxLen   <= (byteIdx == IDX_FULL) ? IDX_FULL : byteIdx + 1'b1;
      end
      if (dpCtl.advance) begin
        if (slotIdx == 4'd9) begin
          slotIdx <= '0;
          if (byteIdx != IDX_FULL) byteIdx <= byteIdx + 1'b1;
        end else begin
          slotIdx <= slotIdx + 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN || dpCtl.frameClr) begin
        byteMem[i] <= '0;
      end else if (dpCtl.capture && dataSlot && byteIdx == IDX_W'(i)) begin
        byteMem[i][~slotIdx[2:0]] <= lineIn;
      end
    end
    assign rxBuf[8*i +: 8] = byteMem[i];
  end

  assign destAddr = byteMem[0][3:0];

endmodule

// File: rtl/cec_rx_ctrl.sv
module cec_rx_ctrl
  import cec_rx_pkg::*;
#(
  parameter int START_LOW_MIN   = 3500,
  parameter int START_TOTAL_MAX = 4700,
  parameter int SAMPLE_AT       = 850,
  parameter int BIT_TOTAL_MIN   = 2050,
  parameter int BIT_TOTAL_MAX   = 2750,
  parameter int ACK_LOW_T       = 1500,
  parameter int ERR_LOW_T       = 3600
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickUs,
  input  logic                  lineIn,
  input  logic [ADDR_SLOTS-1:0] addrMask,
  input  logic [3:0]            slotIdx,
  input  logic                  eomFlag,
  input  logic [3:0]            destAddr,
  output dpCtl_t                dpCtl,
  output logic                  driveLow,
  output logic                  msgValid
);

  localparam int MAX_T = imax(imax(START_TOTAL_MAX, BIT_TOTAL_MAX),
                              imax(ERR_LOW_T, imax(ACK_LOW_T, SAMPLE_AT)));
  localparam int CNT_W = $clog2(MAX_T + 2);
  localparam logic [CNT_W-1:0] T_START_LOW = CNT_W'(START_LOW_MIN);
  localparam logic [CNT_W-1:0] T_START_MAX = CNT_W'(START_TOTAL_MAX);
  localparam logic [CNT_W-1:0] T_SAMPLE    = CNT_W'(SAMPLE_AT);
  localparam logic [CNT_W-1:0] T_BIT_MIN   = CNT_W'(BIT_TOTAL_MIN);
  localparam logic [CNT_W-1:0] T_BIT_MAX   = CNT_W'(BIT_TOTAL_MAX);
  localparam logic [CNT_W-1:0] T_ACK       = CNT_W'(ACK_LOW_T);
  localparam logic [CNT_W-1:0] T_ERR       = CNT_W'(ERR_LOW_T);

  rxState_t         state, nextState;
  logic [CNT_W-1:0] cnt;
  logic             prevLine, fallSeen, restart, validSet, ackMine;
  logic [15:0]      maskExt;

  assign fallSeen = prevLine & ~lineIn;
  assign maskExt  = {1'b0, addrMask};   // slot 15 = broadcast, never ours
  assign ackMine  = maskExt[destAddr];

  always_comb begin
    nextState = state;
    restart   = 1'b0;
    validSet  = 1'b0;
    dpCtl     = '0;
    unique case (state)
      S_IDLE: if (fallSeen) begin
        nextState      = S_START_LOW;
        restart        = 1'b1;
        dpCtl.frameClr = 1'b1;
      end
      S_START_LOW: if (lineIn)
        nextState = (cnt < T_START_LOW) ? S_IDLE : S_START_HIGH;
      S_START_HIGH:
        if (fallSeen) begin
          nextState = S_BIT_SAMPLE;
          restart   = 1'b1;
        end else if (cnt > T_START_MAX) begin
          nextState = S_IDLE;
        end
      S_BIT_SAMPLE: if (cnt >= T_SAMPLE) begin
        dpCtl.capture = 1'b1;
        nextState     = S_BIT_WAIT;
      end
      S_BIT_WAIT:
        if (fallSeen) begin
          restart = 1'b1;
          if (cnt < T_BIT_MIN) begin
            nextState = S_ERR_DRIVE;
          end else begin
            dpCtl.advance = 1'b1;
            if (slotIdx == 4'd8) nextState = ackMine ? S_ACK_DRIVE : S_ACK_POST;
            else                 nextState = S_BIT_SAMPLE;
          end
        end else if (cnt > T_BIT_MAX) begin
          nextState = S_IDLE;
        end
      S_ACK_DRIVE: if (cnt >= T_ACK) nextState = S_ACK_POST;
      S_ACK_POST:
        if (lineIn) begin
          if (eomFlag) begin
            validSet  = 1'b1;
            nextState = S_FINISH;
          end else begin
            nextState = S_BIT_WAIT;
          end
        end else if (cnt > T_BIT_MAX) begin
          nextState = S_IDLE;
        end
      S_FINISH:    if (cnt >= T_BIT_MIN) nextState = S_IDLE;
      S_ERR_DRIVE: if (cnt >= T_ERR) nextState = S_IDLE;
      default:     nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      prevLine <= 1'b1;
      msgValid <= 1'b0;
    end else begin
      state    <= nextState;
      prevLine <= lineIn;
      msgValid <= validSet;
      if (restart)                    cnt <= CNT_W'(1);
      else if (tickUs && cnt != '1)   cnt <= cnt + 1'b1;
    end
  end

  assign driveLow = (state == S_ACK_DRIVE) || (state == S_ERR_DRIVE);

endmodule

// File: rtl/cec_rx_top.sv
module cec_rx_top
  import cec_rx_pkg::*;
#(
  parameter int MAX_BYTES       = 16,
  parameter int START_LOW_MIN   = 3500,
  parameter int START_TOTAL_MAX = 4700,
  parameter int SAMPLE_AT       = 850,
  parameter int BIT_TOTAL_MIN   = 2050,
  parameter int BIT_TOTAL_MAX   = 2750,
  parameter int ACK_LOW_T       = 1500,
  parameter int ERR_LOW_T       = 3600
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           tickUs,
  input  logic                           lineIn,
  input  logic [14:0]                    addrMask,
  output logic                           driveLow,
  output logic [MAX_BYTES*8-1:0]         rxBuf,
  output logic [$clog2(MAX_BYTES+1)-1:0] rxLen,
  output logic                           msgValid
);

  dpCtl_t     dpCtl;
  logic [3:0] slotIdx, destAddr;
  logic       eomFlag;

  cec_rx_ctrl #(
    .START_LOW_MIN(START_LOW_MIN), .START_TOTAL_MAX(START_TOTAL_MAX),
    .SAMPLE_AT(SAMPLE_AT), .BIT_TOTAL_MIN(BIT_TOTAL_MIN),
    .BIT_TOTAL_MAX(BIT_TOTAL_MAX), .ACK_LOW_T(ACK_LOW_T), .ERR_LOW_T(ERR_LOW_T)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .lineIn(lineIn),
    .addrMask(addrMask), .slotIdx(slotIdx), .eomFlag(eomFlag),
    .destAddr(destAddr), .dpCtl(dpCtl), .driveLow(driveLow), .msgValid(msgValid)
  );

  cec_rx_dp #(.MAX_BYTES(MAX_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .dpCtl(dpCtl),
    .slotIdx(slotIdx), .eomFlag(eomFlag), .destAddr(destAddr),
    .rxBuf(rxBuf), .rxLen(rxLen)
  );

endmodule

// File: rtl/cec_rx_chk.sv
module cec_rx_chk #(
  parameter int MAX_BYTES = 16
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           lineIn,
  input logic                           driveLow,
  input logic                           msgValid,
  input logic [$clog2(MAX_BYTES+1)-1:0] rxLen
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |=> !msgValid);  // R5

  AST_VALID_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> $past(lineIn));  // R5

  AST_VALID_HAS_LEN: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (rxLen != '0));  // R5

  AST_LEN_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    rxLen <= ($clog2(MAX_BYTES+1))'(MAX_BYTES));  // R11

  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveLow) |-> (!$past(lineIn) && $past(lineIn, 2)));  // R8

  AST_NO_DRIVE_AT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> !driveLow);  // R9

endmodule

bind cec_rx_top cec_rx_chk #(.MAX_BYTES(MAX_BYTES)) chk_i (
  .clk(clk), .rstN(rstN), .lineIn(lineIn), .driveLow(driveLow),
  .msgValid(msgValid), .rxLen(rxLen)
);

// File: tb/cec_rx_top_tb_top.sv
`timescale 1ns/1ps
module cec_rx_top_tb_top;

  localparam int NB = 16;
  localparam int T_ACK = 150;
  localparam int T_ERR = 360;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickUs = 1'b1;
  logic ext = 1'b1;
  logic lineIn;
  logic [14:0] addrMask = 15'h0011;   // addresses 0 and 4
  logic driveLow, msgValid;
  logic [NB*8-1:0] rxBuf;
  logic [4:0] rxLen;

  assign lineIn = ext & ~driveLow;
  always #2 clk = ~clk;

  cec_rx_top #(
    .MAX_BYTES(NB), .START_LOW_MIN(350), .START_TOTAL_MAX(470), .SAMPLE_AT(85),
    .BIT_TOTAL_MIN(205), .BIT_TOTAL_MAX(275), .ACK_LOW_T(T_ACK), .ERR_LOW_T(T_ERR)
  ) dut_i (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .lineIn(lineIn), .addrMask(addrMask),
    .driveLow(driveLow), .rxBuf(rxBuf), .rxLen(rxLen), .msgValid(msgValid)
  );

  int nTests = 0, nFails = 0;
  int cyc = 0;
  int expFrom = -10, expTo = -10;
  int driveCnt = 0, validCnt = 0, lastValidCyc = -1, expValidCyc = -2;
  bit monOn = 1'b0, finished = 1'b0;
  logic [7:0] fb [20];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference of the drive level, compared every cycle
  always @(negedge clk) begin
    #1;
    if (monOn) begin
      bit expD;
      expD = (cyc >= expFrom) && (cyc <= expTo);
      nTests++;
      if (driveLow !== expD) begin
        nFails++;
        $display("FAIL R7/R8/R9 driveLow at cycle %0d: actual %0d expected %0d",
                 cyc, driveLow, expD);
      end
      if (driveLow) driveCnt++;
      if (msgValid) begin
        validCnt++;
        lastValidCyc = cyc;
      end
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitPulse(input int lowN, input int totN);
    ext = 1'b0;
    waitN(lowN);
    ext = 1'b1;
    waitN(totN - lowN);
  endtask

  function automatic bit isMine(input logic [3:0] d);
    logic [15:0] m;
    m = {1'b0, addrMask};
    return m[d];
  endfunction

  task automatic sendFrame(input int nb, input int startLow, input int startTot,
                           input bit expectRx, input int lowOne, input int lowZero,
                           input int lastTot, input int idleAfter);
    bit mine;
    mine = expectRx && isMine(fb[0][3:0]);
    bitPulse(startLow, startTot);
    for (int b = 0; b < nb; b++) begin
      for (int k = 7; k >= 0; k--) bitPulse(fb[b][k] ? lowOne : lowZero, 240);
      bitPulse((b == nb - 1) ? lowOne : lowZero, 240);
      if (mine) begin
        expFrom = cyc + 1;
        expTo   = cyc + T_ACK;
      end
      if (expectRx && b == nb - 1) expValidCyc = cyc + (mine ? T_ACK + 1 : lowOne) + 1;
      bitPulse(lowOne, (b == nb - 1) ? lastTot : 240);
    end
    ext = 1'b1;
    waitN(idleAfter);
  endtask

  task automatic checkRx(input int nb, input string req);
    int keep;
    keep = (nb > NB) ? NB : nb;
    check(rxLen == 5'(keep), req, "rxLen", rxLen, keep);
    for (int i = 0; i < keep; i++)
      check(rxBuf[8*i +: 8] == fb[i], req, "rxBuf byte", rxBuf[8*i +: 8], fb[i]);
    check(lastValidCyc == expValidCyc, "R5", "msgValid cycle", lastValidCyc, expValidCyc);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R1 watchdog expired: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    int v0, d0;
    waitN(5);
    rstN = 1'b1;
    waitN(2);
    #1;
    check(driveLow == 1'b0, "R1", "driveLow after reset", driveLow, 0);
    check(msgValid == 1'b0, "R1", "msgValid after reset", msgValid, 0);
    check(rxLen == 5'd0, "R1", "rxLen after reset", rxLen, 0);
    monOn = 1'b1;
    waitN(20);

    // R4 R5 R8: directed to address 4, two bytes
    fb[0] = 8'h34; fb[1] = 8'hA5;
    v0 = validCnt; d0 = driveCnt;
    sendFrame(2, 370, 450, 1, 60, 150, 240, 600);
    check(validCnt == v0 + 1, "R5", "msgValid pulses", validCnt - v0, 1);
    check(driveCnt == d0 + 2 * T_ACK, "R8", "ack drive cycles", driveCnt - d0, 2 * T_ACK);
    checkRx(2, "R4");

    // R2 boundary: start low exactly minimum, sample-point lows 84/86
    fb[0] = 8'h6B;
    v0 = validCnt;
    sendFrame(1, 350, 450, 1, 84, 86, 240, 600);
    check(validCnt == v0 + 1, "R2", "minimum start accepted", validCnt - v0, 1);
    checkRx(1, "R4");

    // R2: start low one tick short
    fb[0] = 8'h34; fb[1] = 8'h11;
    v0 = validCnt; d0 = driveCnt;
    sendFrame(2, 349, 450, 0, 60, 150, 240, 600);
    check(validCnt == v0, "R2", "short start msgValid", validCnt - v0, 0);
    check(driveCnt == d0, "R2", "short start drive", driveCnt - d0, 0);

    // R3: start bit too long
    v0 = validCnt;
    sendFrame(2, 370, 600, 0, 60, 150, 240, 600);
    check(validCnt == v0, "R3", "long start msgValid", validCnt - v0, 0);

    // R6: bus stays high mid-byte, then a good frame
    v0 = validCnt;
    bitPulse(370, 450);
    for (int k = 0; k < 4; k++) bitPulse(60, 240);
    waitN(400);
    check(validCnt == v0, "R6", "abandoned frame msgValid", validCnt - v0, 0);
    fb[0] = 8'h40;
    sendFrame(1, 370, 450, 1, 60, 150, 240, 600);
    check(validCnt == v0 + 1, "R6", "frame after abandon", validCnt - v0, 1);
    checkRx(1, "R6");

    // R7: bit period too short
    v0 = validCnt; d0 = driveCnt;
    bitPulse(370, 450);
    bitPulse(60, 240);
    bitPulse(60, 150);
    expFrom = cyc + 1;
    expTo   = cyc + T_ERR;
    bitPulse(150, 240);
    ext = 1'b1;
    waitN(700);
    check(driveCnt == d0 + T_ERR, "R7", "error drive cycles", driveCnt - d0, T_ERR);
    check(validCnt == v0, "R7", "error frame msgValid", validCnt - v0, 0);

    // R9: broadcast and foreign destination
    fb[0] = 8'h3F; fb[1] = 8'hC3;
    v0 = validCnt; d0 = driveCnt;
    sendFrame(2, 370, 450, 1, 60, 150, 240, 600);
    check(driveCnt == d0, "R9", "broadcast drive", driveCnt - d0, 0);
    checkRx(2, "R9");
    fb[0] = 8'h43; fb[1] = 8'h5A;
    d0 = driveCnt;
    sendFrame(2, 370, 450, 1, 60, 150, 240, 600);
    check(driveCnt == d0, "R9", "foreign drive", driveCnt - d0, 0);
    check(validCnt == v0 + 2, "R9", "msgValid count", validCnt - v0, 2);
    checkRx(2, "R9");

    // R10: next edge inside the finish guard is ignored
    fb[0] = 8'h3F;
    v0 = validCnt;
    sendFrame(1, 370, 450, 1, 60, 150, 190, 0);
    fb[0] = 8'h43;
    sendFrame(1, 370, 450, 0, 60, 150, 240, 600);
    check(validCnt == v0 + 1, "R10", "guarded edge", validCnt - v0, 1);
    fb[0] = 8'h3F;
    sendFrame(1, 370, 450, 1, 60, 150, 210, 0);
    fb[0] = 8'h43;
    sendFrame(1, 370, 450, 1, 60, 150, 240, 600);
    check(validCnt == v0 + 3, "R10", "edge after guard", validCnt - v0, 3);
    checkRx(1, "R10");

    // R11: seventeen bytes
    for (int i = 0; i < 17; i++) fb[i] = 8'(8'h34 + 8'(i * 13));
    v0 = validCnt;
    sendFrame(17, 370, 450, 1, 60, 150, 240, 600);
    check(validCnt == v0 + 1, "R11", "long frame msgValid", validCnt - v0, 1);
    checkRx(17, "R11");

    // R12: buffer cleared between frames
    fb[0] = 8'hFF; fb[1] = 8'hFF; fb[2] = 8'hFF;
    sendFrame(3, 370, 450, 1, 60, 150, 240, 600);
    fb[0] = 8'h30;
    sendFrame(1, 370, 450, 1, 60, 150, 240, 600);
    checkRx(1, "R12");
    for (int i = 1; i < 3; i++)
      check(rxBuf[8*i +: 8] == 8'h00, "R12", "stale byte", rxBuf[8*i +: 8], 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule